// File: doc/BRIEF.md
# Streaming 3x3 Binary Neighborhood Filter

This block filters a one-bit image that arrives as a raster stream, one pixel per accepted cycle, row after row. Two chained line delays hold the last two rows plus a few pixels. This turns pixels that touch in the image into taps that sit side by side in hardware, so a full 3x3 window around one centre pixel is available at every step. The nine window bits address a 512-entry one-bit table, and the entry read out becomes the filtered pixel. Erosion, dilation, majority, edge marking and shifts are all loaded as table contents, and the same function is applied to every pixel of a frame.

Image width and height are parameters. After the last pixel of a frame the block runs on its own to emit the final line of results, so the source does not have to pad the image. Table writes go to a pending copy that is moved into the working copy only when a new frame starts. A single frame is therefore never filtered with a mix of two functions.

Top module: `nbf_filter3x3`

## Requirements
- R1: A pixel is taken on each cycle with `in_valid` high while a frame is open. `in_valid` together with `in_sof` starts a new frame at image position (0,0) from any state, dropping any unfinished frame. Pixels follow row-major raster order: IMG_W per row, IMG_H rows.
- R2: The table address is built from the window in row-major order. Bit 8 is the pixel above-left of the centre, bit 4 is the centre and bit 0 is below-right. The output pixel is the table entry at that address.
- R3: Window positions outside the image read as 0, on all four edges and at the corners.
- R4: Each frame yields exactly IMG_W*IMG_H output pixels in raster order. With unbroken input, the result for pixel k is on the output IMG_W+2 clock edges after the edge that samples pixel k.
- R5: After the last pixel of a frame, the remaining IMG_W+1 results are produced over the next IMG_W+1 cycles without further input. `in_valid` without `in_sof` is ignored while no frame is open and during that drain.
- R6: Writes through `lut_we`/`lut_addr`/`lut_data` go to a pending table. The pending table becomes the working table at the cycle a start of frame is accepted. A write in that same cycle applies only from the following frame.
- R7: After reset `out_valid` and `out_pix` are low, and both tables hold the pass-through function: entry a equals bit 4 of a.
- R8: `out_valid` is high only in the cycle after a step that completes a window, and `out_pix` is 0 whenever `out_valid` is low. Cycles with `in_valid` low inside a frame stall the filter without changing any result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel present |
| in_sof | input | 1 | Marks the first pixel of a frame |
| in_pix | input | 1 | Input pixel value |
| lut_we | input | 1 | Write strobe for the pending table |
| lut_addr | input | 9 | Table entry to write |
| lut_data | input | 1 | Value written to the entry |
| out_valid | output | 1 | Filtered pixel present |
| out_pix | output | 1 | Filtered pixel value |

## Verification
Single-tap functions (above-left only, below-right only) pin down the address bit order. A design with the row or column order reversed shifts the image the wrong way. An all-ones image under an "all nine set" function exposes border handling: a design that wraps the neighbouring row or column, or reads stale line-buffer data, leaves ones on the frame edge. A table entry is rewritten mid-frame and again in the start-of-frame cycle, against an image with isolated pixels. A design that switches tables early changes results inside the running frame. Random stalls, junk valid pixels during idle and drain, and a frame restarted halfway check that the output count, order and latency do not depend on input timing.

// File: rtl/nbf_pkg.sv
package nbf_pkg;

  localparam int WIN_BITS   = 9;
  localparam int LUT_DEPTH  = 1 << WIN_BITS;
  localparam int CENTER_BIT = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_FLUSH = 2'd2
  } nbf_state_e;

  // Table whose entry a returns the window centre bit of a
  function automatic logic [LUT_DEPTH-1:0] pass_table();
    logic [LUT_DEPTH-1:0] t;
    logic [WIN_BITS-1:0]  av;
    for (int a = 0; a < LUT_DEPTH; a++) begin
      av   = WIN_BITS'(a);
      t[a] = av[CENTER_BIT];
    end
    return t;
  endfunction

endpackage

// File: rtl/nbf_line_delay.sv
module nbf_line_delay #(
  parameter int LEN     = 65,
  parameter int HEAD_N  = 3,
  parameter int TAIL_N  = 1
) (
  input  logic              clk,
  input  logic              en,
  input  logic              din,
  output logic [HEAD_N-1:0] head,
  output logic [TAIL_N-1:0] tail
);

  logic [LEN-1:0] q_r;
  logic [LEN-1:0] q_nxt;

  always_comb begin
    q_nxt = {q_r[LEN-2:0], din};
  end

  // Data path only: no reset, contents are masked until they are valid
  always_ff @(posedge clk) begin
    if (en) q_r <= q_nxt;
  end

  // head[i] is the pixel stepped in i steps ago
  for (genvar h = 0; h < HEAD_N; h++) begin : g_head
    assign head[h] = q_r[h];
  end

  // tail[TAIL_N-1] is the oldest stored pixel
  for (genvar t = 0; t < TAIL_N; t++) begin : g_tail
    assign tail[t] = q_r[LEN-TAIL_N+t];
  end

endmodule

// File: rtl/nbf_raster_ctrl.sv
module nbf_raster_ctrl
  import nbf_pkg::*;
#(
  parameter int IMG_W = 64,
  parameter int IMG_H = 64,
  parameter int CW    = $clog2(IMG_W + 1),
  parameter int RW    = $clog2(IMG_H + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sof,
  output logic          take_pix,
  output logic          step,
  output logic          table_load,
  output logic          win_vld,
  output logic [RW-1:0] crow,
  output logic [CW-1:0] ccol
);

  localparam logic [RW-1:0] ROW_ONE  = RW'(1);
  localparam logic [RW-1:0] ROW_LAST = RW'(IMG_H - 1);
  localparam logic [RW-1:0] ROW_PAD  = RW'(IMG_H);
  localparam logic [CW-1:0] COL_ONE  = CW'(1);
  localparam logic [CW-1:0] COL_LAST = CW'(IMG_W - 1);
  localparam logic [CW-1:0] COL_END  = CW'(IMG_W);
  localparam logic [CW-1:0] COL_PEN  = CW'(IMG_W - 2);

  nbf_state_e    state_q, state_d;
  logic [RW-1:0] prow_q, prow_d, crow_q, crow_d, cur_row;
  logic [CW-1:0] pcol_q, pcol_d, ccol_q, ccol_d, cur_col;
  logic          win_q, win_d;
  logic          sof_go, take, stp, cen_hit, cen_first;

  always_comb begin
    sof_go    = in_valid & in_sof;
    take      = sof_go | ((state_q == ST_FILL) & in_valid);
    stp       = take | ((state_q == ST_FLUSH) & ~sof_go);
    cur_row   = sof_go ? '0 : prow_q;
    cur_col   = sof_go ? '0 : pcol_q;
    cen_first = (cur_row == ROW_ONE) && (cur_col == COL_ONE);
    cen_hit   = stp && ((cur_row > ROW_ONE) ||
                        ((cur_row == ROW_ONE) && (cur_col != '0)));

    state_d = state_q;
    prow_d  = prow_q;
    pcol_d  = pcol_q;
    crow_d  = crow_q;
    ccol_d  = ccol_q;
    win_d   = cen_hit;

    if (stp) begin
      if (cur_row == ROW_PAD) begin
        prow_d  = cur_row;
        pcol_d  = cur_col + CW'(1);
        state_d = (cur_col == COL_END) ? ST_IDLE : ST_FLUSH;
      end else if (cur_col == COL_LAST) begin
        prow_d  = cur_row + RW'(1);
        pcol_d  = '0;
        state_d = (cur_row == ROW_LAST) ? ST_FLUSH : ST_FILL;
      end else begin
        prow_d  = cur_row;
        pcol_d  = cur_col + CW'(1);
        state_d = ST_FILL;
      end
    end

    if (cen_hit) begin
      if (cen_first) begin
        crow_d = '0;
        ccol_d = '0;
      end else if (ccol_q == COL_LAST) begin
        crow_d = crow_q + RW'(1);
        ccol_d = '0;
      end else begin
        ccol_d = ccol_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      prow_q  <= '0;
      pcol_q  <= '0;
      crow_q  <= '0;
      ccol_q  <= '0;
      win_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      win_q   <= win_d;
      if (stp) begin
        prow_q <= prow_d;
        pcol_q <= pcol_d;
      end
      if (cen_hit) begin
        crow_q <= crow_d;
        ccol_q <= ccol_d;
      end
    end
  end

  assign take_pix   = take;
  assign step       = stp;
  assign table_load = sof_go;
  assign win_vld    = win_q;
  assign crow       = crow_q;
  assign ccol       = ccol_q;

  // R1
  sof_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof) |=> (state_q == ST_FILL && prow_q == '0 && pcol_q == COL_ONE));

  // R4
  frame_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stp && state_q == ST_FLUSH && !sof_go && pcol_q == COL_END)
      |-> (crow_q == ROW_LAST && ccol_q == COL_PEN));

  // R5
  idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !(in_valid && in_sof))
      |=> (!win_q && $stable(prow_q) && $stable(pcol_q)));

endmodule

// File: rtl/nbf_lut_bank.sv
module nbf_lut_bank
  import nbf_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [WIN_BITS-1:0] wr_addr,
  input  logic                wr_bit,
  input  logic                load,
  input  logic [WIN_BITS-1:0] rd_addr,
  output logic                rd_bit
);

  localparam logic [LUT_DEPTH-1:0] RESET_TABLE = pass_table();

  logic [LUT_DEPTH-1:0] pend_q, pend_d;
  logic [LUT_DEPTH-1:0] work_q, work_d;

  always_comb begin
    pend_d = pend_q;
    if (wr_en) pend_d[wr_addr] = wr_bit;
    work_d = load ? pend_q : work_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= RESET_TABLE;
      work_q <= RESET_TABLE;
    end else begin
      if (wr_en) pend_q <= pend_d;
      if (load)  work_q <= work_d;
    end
  end

  assign rd_bit = work_q[rd_addr];

  // R6
  work_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(work_q));

endmodule

// File: rtl/nbf_window_out.sv
module nbf_window_out
  import nbf_pkg::*;
#(
  parameter int IMG_W = 64,
  parameter int IMG_H = 64,
  parameter int CW    = $clog2(IMG_W + 1),
  parameter int RW    = $clog2(IMG_H + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WIN_BITS-1:0] taps,
  input  logic [RW-1:0]       crow,
  input  logic [CW-1:0]       ccol,
  input  logic                win_vld,
  output logic [WIN_BITS-1:0] rd_addr,
  input  logic                rd_bit,
  output logic                out_valid,
  output logic                out_pix
);

  localparam logic [RW-1:0] ROW_LAST = RW'(IMG_H - 1);
  localparam logic [CW-1:0] COL_LAST = CW'(IMG_W - 1);

  logic [2:0] row_ok, col_ok;
  logic       vld_q, vld_d, pix_q, pix_d;

  always_comb begin
    row_ok = {crow != '0, 1'b1, crow != ROW_LAST};
    col_ok = {ccol != '0, 1'b1, ccol != COL_LAST};
  end

  // Position i: window row (8-i)/3, column (8-i)%3, index 2 is top / left
  for (genvar i = 0; i < WIN_BITS; i++) begin : g_mask
    localparam int WR = (WIN_BITS - 1 - i) / 3;
    localparam int WC = (WIN_BITS - 1 - i) % 3;
    assign rd_addr[i] = taps[i] & row_ok[2-WR] & col_ok[2-WC];
  end

  always_comb begin
    vld_d = win_vld;
    pix_d = win_vld & rd_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      pix_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      pix_q <= pix_d;
    end
  end

  assign out_valid = vld_q;
  assign out_pix   = pix_q;

  // R3
  top_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vld && crow == '0) |-> (rd_addr[8:6] == 3'b000));

  // R3
  left_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vld && ccol == '0) |-> (!rd_addr[8] && !rd_addr[5] && !rd_addr[2]));

  // R8
  out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> !pix_q);

endmodule

// File: rtl/nbf_filter3x3.sv
module nbf_filter3x3
  import nbf_pkg::*;
#(
  parameter int IMG_W = 64,
  parameter int IMG_H = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_sof,
  input  logic                in_pix,
  input  logic                lut_we,
  input  logic [WIN_BITS-1:0] lut_addr,
  input  logic                lut_data,
  output logic                out_valid,
  output logic                out_pix
);

  localparam int CW = $clog2(IMG_W + 1);
  localparam int RW = $clog2(IMG_H + 1);

  logic                rst_s1, rst_s2;
  logic                take_pix, step, table_load, win_vld;
  logic [RW-1:0]       crow;
  logic [CW-1:0]       ccol;
  logic                feed_pix;
  logic [2:0]          near_head;
  logic [0:0]          near_tail;
  logic [1:0]          far_head;
  logic [2:0]          far_tail;
  logic [WIN_BITS-1:0] taps, rd_addr;
  logic                rd_bit;

  // Reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  nbf_raster_ctrl #(.IMG_W(IMG_W), .IMG_H(IMG_H), .CW(CW), .RW(RW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_s2),
    .in_valid   (in_valid),
    .in_sof     (in_sof),
    .take_pix   (take_pix),
    .step       (step),
    .table_load (table_load),
    .win_vld    (win_vld),
    .crow       (crow),
    .ccol       (ccol)
  );

  assign feed_pix = take_pix & in_pix;

  // Newest pixel, its two predecessors, and the pixel one line back
  nbf_line_delay #(.LEN(IMG_W + 1), .HEAD_N(3), .TAIL_N(1)) u_near (
    .clk  (clk),
    .en   (step),
    .din  (feed_pix),
    .head (near_head),
    .tail (near_tail)
  );

  // Centre row from the second tap pair, upper row from the tail
  nbf_line_delay #(.LEN(IMG_W + 2), .HEAD_N(2), .TAIL_N(3)) u_far (
    .clk  (clk),
    .en   (step),
    .din  (near_tail[0]),
    .head (far_head),
    .tail (far_tail)
  );

  assign taps = {far_tail[2], far_tail[1], far_tail[0],
                 far_head[1], far_head[0], near_tail[0],
                 near_head[2], near_head[1], near_head[0]};

  nbf_lut_bank u_lut (
    .clk     (clk),
    .rst_n   (rst_s2),
    .wr_en   (lut_we),
    .wr_addr (lut_addr),
    .wr_bit  (lut_data),
    .load    (table_load),
    .rd_addr (rd_addr),
    .rd_bit  (rd_bit)
  );

  nbf_window_out #(.IMG_W(IMG_W), .IMG_H(IMG_H), .CW(CW), .RW(RW)) u_out (
    .clk       (clk),
    .rst_n     (rst_s2),
    .taps      (taps),
    .crow      (crow),
    .ccol      (ccol),
    .win_vld   (win_vld),
    .rd_addr   (rd_addr),
    .rd_bit    (rd_bit),
    .out_valid (out_valid),
    .out_pix   (out_pix)
  );

endmodule

// File: tb/tb_nbf_filter3x3.sv
`timescale 1ns/100ps
module tb_nbf_filter3x3;

  localparam int W    = 8;
  localparam int H    = 5;
  localparam int NPIX = W * H;
  localparam int MAXO = 4096;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       in_valid = 1'b0, in_sof = 1'b0, in_pix = 1'b0;
  logic       lut_we = 1'b0, lut_data = 1'b0;
  logic [8:0] lut_addr = '0;
  logic       out_valid, out_pix;

  int checks = 0, errors = 0, cyc = 0, got_n = 0;
  bit got_pix[MAXO];
  int got_cyc[MAXO];
  bit img[H][W];
  bit lut_sh[512];
  bit lut_act[512];

  nbf_filter3x3 #(.IMG_W(W), .IMG_H(H)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_pix(in_pix),
    .lut_we(lut_we), .lut_addr(lut_addr), .lut_data(lut_data),
    .out_valid(out_valid), .out_pix(out_pix)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (out_valid && got_n < MAXO) begin
      got_pix[got_n] = out_pix;
      got_cyc[got_n] = cyc;
      got_n++;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL R1 watchdog: actual %0d cycles expected below 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit fn_val(int kind, int a);
    logic [8:0] v;
    v = 9'(a);
    case (kind)
      1: return v[8];
      2: return v[0];
      3: return v == 9'h1ff;
      4: return $countones(v) >= 5;
      default: return v[4];
    endcase
  endfunction

  function automatic bit exp_out(int r, int c);
    int a;
    a = 0;
    for (int dr = 0; dr < 3; dr++) begin
      for (int dc = 0; dc < 3; dc++) begin
        int rr, cc;
        bit b;
        rr = r - 1 + dr;
        cc = c - 1 + dc;
        b  = 1'b0;
        if (rr >= 0 && rr < H && cc >= 0 && cc < W) b = img[rr][cc];
        if (b) a = a | (1 << (8 - (dr * 3 + dc)));
      end
    end
    return lut_act[a];
  endfunction

  task automatic fill_img(int density);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++)
        img[r][c] = ($urandom_range(99) < density);
  endtask

  task automatic lut_load(int kind);
    for (int a = 0; a < 512; a++) begin
      @(negedge clk);
      lut_we = 1'b1; lut_addr = 9'(a); lut_data = fn_val(kind, a);
      lut_sh[a] = lut_data;
    end
    @(negedge clk);
    lut_we = 1'b0;
  endtask

  // Drives one frame; stop_at >= 0 abandons it after that many pixels
  task automatic send_frame(string req, int gap_pct, bit junk, int stop_at,
                            int wr_at, int wr_addr, bit wr_val, bit chk_lat);
    int k, sof_cyc, first, seen, bad_r, bad_c, bad_a, bad_e, base_n;
    bit lat_ok;
    k = 0; sof_cyc = 0;
    if (junk) begin
      base_n = got_n;
      for (int j = 0; j < 4; j++) begin
        @(negedge clk); in_valid = 1'b1; in_sof = 1'b0; in_pix = 1'b1;
      end
      @(negedge clk); in_valid = 1'b0;
      repeat (W + 4) @(negedge clk);
      #1 chk(got_n == base_n, "R5", "outputs from idle junk", got_n - base_n, 0);
    end
    while (k < NPIX) begin
      if (stop_at >= 0 && k == stop_at) break;
      @(negedge clk);
      lut_we = 1'b0;
      if (k > 0 && $urandom_range(99) < gap_pct) begin
        in_valid = 1'b0; in_sof = 1'b0; in_pix = 1'($urandom);
        continue;
      end
      in_valid = 1'b1; in_sof = (k == 0); in_pix = img[k / W][k % W];
      if (k == 0) begin
        lut_act = lut_sh;
        sof_cyc = cyc;
      end
      if (k == wr_at) begin
        lut_we = 1'b1; lut_addr = 9'(wr_addr); lut_data = wr_val;
        lut_sh[wr_addr] = wr_val;
      end
      k++;
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; lut_we = 1'b0;
    if (stop_at >= 0) return;
    for (int j = 0; j < W; j++) begin
      @(negedge clk); in_valid = junk; in_pix = 1'b1;
    end
    @(negedge clk); in_valid = 1'b0;
    repeat (W + 8) @(negedge clk);
    #1;
    seen = 0; first = -1; bad_r = -1; bad_c = 0; bad_a = 0; bad_e = 0;
    for (int i = 0; i < got_n; i++) begin
      if (got_cyc[i] >= sof_cyc + 3) begin
        if (first < 0) first = got_cyc[i];
        if (seen < NPIX && bad_r < 0 && got_pix[i] != exp_out(seen / W, seen % W)) begin
          bad_r = seen / W; bad_c = seen % W;
          bad_a = got_pix[i]; bad_e = exp_out(seen / W, seen % W);
        end
        seen++;
      end
    end
    chk(seen == NPIX, "R4", "output count per frame", seen, NPIX);
    if (bad_r >= 0)
      $display("  (first mismatch at row %0d col %0d)", bad_r, bad_c);
    chk(bad_r < 0, req, "filtered pixel value", bad_a, bad_e);
    if (chk_lat) begin
      lat_ok = (first == sof_cyc + W + 3);
      chk(lat_ok, "R4", "latency in cycles", first - sof_cyc - 1, W + 2);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R7", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0 && out_pix == 1'b0, "R7", "outputs after reset",
        {out_valid, out_pix}, 0);
    for (int a = 0; a < 512; a++) begin
      lut_sh[a] = fn_val(0, a);
      lut_act[a] = lut_sh[a];
    end
  endtask

  // R7 R2: default pass-through table, unbroken stream
  task automatic t_passthrough();
    fill_img(50);
    send_frame("R7", 0, 1'b0, -1, -1, 0, 1'b0, 1'b1);
  endtask

  // R2 R3: single-tap tables shift the image from each corner
  task automatic t_corner_taps();
    fill_img(50);
    lut_load(1);
    send_frame("R2", 0, 1'b0, -1, -1, 0, 1'b0, 1'b1);
    lut_load(2);
    send_frame("R2", 0, 1'b0, -1, -1, 0, 1'b0, 1'b0);
  endtask

  // R3: all ones under "all nine set" leaves the frame edge at 0
  task automatic t_border();
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++)
        img[r][c] = 1'b1;
    lut_load(3);
    send_frame("R3", 0, 1'b0, -1, -1, 0, 1'b0, 1'b0);
  endtask

  // R8: majority with random stalls
  task automatic t_stalls();
    fill_img(50);
    lut_load(4);
    send_frame("R8", 40, 1'b0, -1, -1, 0, 1'b0, 1'b0);
    fill_img(30);
    send_frame("R8", 70, 1'b0, -1, -1, 0, 1'b0, 1'b0);
  endtask

  // R5: junk valid pixels while idle and during the drain
  task automatic t_junk();
    fill_img(50);
    lut_load(0);
    send_frame("R5", 0, 1'b1, -1, -1, 0, 1'b0, 1'b1);
  endtask

  // R6: table changes apply only at the next start of frame
  task automatic t_table_swap();
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++)
        img[r][c] = 1'b0;
    img[0][0] = 1'b1; img[2][3] = 1'b1; img[4][6] = 1'b1; img[1][W-1] = 1'b1;
    send_frame("R6", 0, 1'b0, -1, NPIX / 2, 9'h010, 1'b0, 1'b0);
    send_frame("R6", 0, 1'b0, -1, 0, 9'h010, 1'b1, 1'b0);
    send_frame("R6", 0, 1'b0, -1, -1, 0, 1'b0, 1'b0);
  endtask

  // R1: a frame abandoned halfway, then a full one
  task automatic t_restart();
    fill_img(60);
    send_frame("R1", 0, 1'b0, NPIX / 2, -1, 0, 1'b0, 1'b0);
    fill_img(40);
    send_frame("R1", 0, 1'b0, -1, -1, 0, 1'b0, 1'b1);
  endtask

  initial begin
    void'($urandom(32'd7));
    t_reset();
    t_passthrough();
    t_corner_taps();
    t_border();
    t_stalls();
    t_junk();
    t_table_swap();
    t_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule